// File: doc/BRIEF.md
# Transceiver Path Reset Sequencer

This block brings one serial transceiver data path, transmit or receive, out of reset in a fixed order. It first holds the serializer in reset, then releases it while it keeps the protocol layer in reset, then watches the lock indication (and, on a receive path, the error indication) for a stability window before it raises a ready flag. After that it keeps watching. Sustained loss of lock restarts the whole sequence. Sustained receive errors during the stability window restart only the protocol-layer stage.

All of its logic runs on the reference clock with a synchronous, active-high reset. Four external requests can force a restart. A shared and a per-path serializer request each return the block to the serializer stage. A shared and a per-path protocol request each return it to the protocol stage. Each phase length is set by a counter width parameter. Narrow serializer and protocol counters suit a transmit path, and wide ones suit a receive path. On a transmit path the error input is tied low.

Top module: `xcvr_path_rst_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the serializer-reset phase, so `ser_rst_o`=1, `proto_rst_o`=1 and `ready_o`=0 after that edge.
- R2: The outputs are decoded from the phase as follows. `ser_rst_o` is high only in the serializer-reset phase. `proto_rst_o` is high in the serializer-reset and protocol-reset phases. `ready_o` is high only in the ready phase. All three are low in the stability-check phase.
- R3: With no forcing input and `lol_i` low, the serializer-reset phase lasts 2^SER_CNT_W cycles and the protocol-reset phase lasts 2^PROTO_CNT_W cycles. The block then enters the stability-check phase.
- R4: If `ser_rst_shared_i` or `ser_rst_path_i` is high at an edge, the block is in the serializer-reset phase after that edge and its phase timer restarts from zero. The full sequence then runs again.
- R5: If `proto_rst_shared_i` or `proto_rst_path_i` is high at an edge while the block is in any phase other than serializer reset, the block enters the protocol-reset phase with a fresh timer. In the serializer-reset phase these inputs have no effect.
- R6: A loss counter counts consecutive cycles with `lol_i` high and clears when `lol_i` is low. Once it reaches 2^LOSS_CNT_W−1, the next edge returns the block to the serializer-reset phase from any phase. The block stays there while `lol_i` remains high. A shorter high run has no effect.
- R7: A lock counter advances on each cycle with `lol_i` low. It clears when `lol_i` is high or when either reset output is high. The block moves from stability check to ready when the lock counter has completed, so a clean check lasts 2^LOCK_CNT_W cycles.
- R8: In the stability-check phase, each cycle with `rx_err_i` high increments an error counter. The error cycles need not be consecutive. The counter clears outside that phase. Once it reaches 2^ERR_CNT_W−1, the next edge sends the block to the protocol-reset phase. This takes priority over a lock completion in the same cycle.
- R9: `rx_err_i` has no effect outside the stability-check phase. Errors in the ready phase keep the block ready. Errors during the reset phases do not shorten a later stability check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_rst_shared_i | input | 1 | Serializer reset request shared by the paths of a pair |
| ser_rst_path_i | input | 1 | Serializer reset request for this path |
| proto_rst_shared_i | input | 1 | Protocol-layer reset request shared by the pair |
| proto_rst_path_i | input | 1 | Protocol-layer reset request for this path |
| lol_i | input | 1 | Loss of lock (transmit) or loss of signal (receive), high when lost |
| rx_err_i | input | 1 | Receive code or disparity error; tie low on a transmit path |
| ser_rst_o | output | 1 | Serializer reset, active high |
| proto_rst_o | output | 1 | Protocol-layer reset, active high |
| ready_o | output | 1 | Path is locked and stable |

## Verification
On every cycle the assertions check the phase-to-phase rules. A serializer request or a completed loss count leads to the serializer phase on the next cycle. A protocol request outside the serializer phase leads to the protocol phase. The serializer phase can only exit into the protocol phase. Ready can only rise out of the stability check. The counters never wrap, and lock and loss completion clear one cycle after their opposing level. The exact phase lengths cannot be checked that way, and the directed scenarios cover them instead. They also cover the filtering of a short loss-of-lock run, the restart of the lock window after a one-cycle blip, the counting of non-consecutive errors, error-over-lock priority, and the inputs that must be ignored.

// File: rtl/xrst_pkg.sv
package xrst_pkg;

    typedef enum logic [1:0] {
        PH_SER   = 2'd0,
        PH_PROTO = 2'd1,
        PH_CHECK = 2'd2,
        PH_READY = 2'd3
    } phase_e;

    typedef struct packed {
        logic ser_rst;
        logic proto_rst;
        logic ready;
    } rst_out_s;

    function automatic rst_out_s decode_phase(phase_e p);
        rst_out_s o;
        o.ser_rst   = (p == PH_SER);
        o.proto_rst = (p == PH_SER) || (p == PH_PROTO);
        o.ready     = (p == PH_READY);
        return o;
    endfunction

    function automatic int unsigned last_count(int unsigned w);
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/xrst_sat_cnt.sv
module xrst_sat_cnt #(
    parameter int unsigned W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != MAXV))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == MAXV);

    // R6/R7/R8: a completed count stays completed until cleared (no wrap)
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);

endmodule

// File: rtl/xrst_link_mon.sv
module xrst_link_mon #(
    parameter int unsigned LOSS_W = 13,
    parameter int unsigned LOCK_W = 11,
    parameter int unsigned ERR_W  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic lol_i,
    input  logic rx_err_i,
    input  logic hold_i,
    input  logic in_check_i,
    output logic loss_done,
    output logic lock_done,
    output logic err_done
);
    logic lock_clr;
    logic err_clr;

    assign lock_clr = lol_i || hold_i;
    assign err_clr  = !in_check_i;

    xrst_sat_cnt #(.W(LOSS_W)) u_loss (
        .clk(clk), .rst(rst), .clr(!lol_i), .inc(lol_i), .done(loss_done)
    );

    xrst_sat_cnt #(.W(LOCK_W)) u_lock (
        .clk(clk), .rst(rst), .clr(lock_clr), .inc(1'b1), .done(lock_done)
    );

    xrst_sat_cnt #(.W(ERR_W)) u_err (
        .clk(clk), .rst(rst), .clr(err_clr), .inc(rx_err_i), .done(err_done)
    );

    // R7: loss of lock restarts the lock window
    a_r7_lock_clear: assert property (@(posedge clk) disable iff (rst)
        lol_i |=> !lock_done);

    // R6: a low lol_i breaks any loss run
    a_r6_loss_clear: assert property (@(posedge clk) disable iff (rst)
        !lol_i |=> !loss_done);

    // R9: error count cannot be complete outside the check phase
    a_r9_err_scope: assert property (@(posedge clk) disable iff (rst)
        !in_check_i |=> !err_done);

endmodule

// File: rtl/xrst_phase_fsm.sv
module xrst_phase_fsm
    import xrst_pkg::*;
#(
    parameter int unsigned SER_W   = 2,
    parameter int unsigned PROTO_W = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   force_ser,
    input  logic   force_proto,
    input  logic   loss_done,
    input  logic   lock_done,
    input  logic   err_done,
    output phase_e phase
);
    localparam int unsigned TW = (SER_W > PROTO_W) ? SER_W : PROTO_W;
    localparam logic [TW-1:0] SER_LAST   = TW'(last_count(SER_W));
    localparam logic [TW-1:0] PROTO_LAST = TW'(last_count(PROTO_W));

    phase_e        nxt;
    logic          restart;
    logic [TW-1:0] tmr;

    always_comb begin
        nxt     = phase;
        restart = 1'b0;
        if (force_ser || loss_done) begin
            nxt     = PH_SER;
            restart = 1'b1;
        end else if (force_proto && (phase != PH_SER)) begin
            nxt     = PH_PROTO;
            restart = 1'b1;
        end else begin
            case (phase)
                PH_SER:   if (tmr == SER_LAST) nxt = PH_PROTO;
                PH_PROTO: if (tmr == PROTO_LAST) nxt = PH_CHECK;
                PH_CHECK: begin
                    if (err_done)       nxt = PH_PROTO;
                    else if (lock_done) nxt = PH_READY;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SER;
            tmr   <= '0;
        end else begin
            phase <= nxt;
            if (restart || (nxt != phase))
                tmr <= '0;
            else if ((phase == PH_SER) || (phase == PH_PROTO))
                tmr <= tmr + 1'b1;
        end
    end

    // R6: completed loss count returns to the serializer phase
    a_r6_loss_to_ser: assert property (@(posedge clk) disable iff (rst)
        loss_done |=> (phase == PH_SER));

    // R8: completed error count in the check phase leads to protocol reset
    a_r8_err_to_proto: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CHECK && err_done && !force_ser && !loss_done) |=> (phase == PH_PROTO));

    // R3: the serializer phase only exits into the protocol phase
    a_r3_ser_exit: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SER && !force_ser && !loss_done) |=> (phase inside {PH_SER, PH_PROTO}));

endmodule

// File: rtl/xcvr_path_rst_seq.sv
module xcvr_path_rst_seq
    import xrst_pkg::*;
#(
    parameter int unsigned SER_CNT_W   = 2,
    parameter int unsigned PROTO_CNT_W = 3,
    parameter int unsigned LOCK_CNT_W  = 11,
    parameter int unsigned ERR_CNT_W   = 6,
    parameter int unsigned LOSS_CNT_W  = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_rst_shared_i,
    input  logic ser_rst_path_i,
    input  logic proto_rst_shared_i,
    input  logic proto_rst_path_i,
    input  logic lol_i,
    input  logic rx_err_i,
    output logic ser_rst_o,
    output logic proto_rst_o,
    output logic ready_o
);
    phase_e   phase;
    rst_out_s outs;
    logic     force_ser;
    logic     force_proto;
    logic     loss_done;
    logic     lock_done;
    logic     err_done;

    assign force_ser   = ser_rst_shared_i || ser_rst_path_i;
    assign force_proto = proto_rst_shared_i || proto_rst_path_i;
    assign outs        = decode_phase(phase);

    xrst_link_mon #(
        .LOSS_W(LOSS_CNT_W),
        .LOCK_W(LOCK_CNT_W),
        .ERR_W (ERR_CNT_W)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .lol_i     (lol_i),
        .rx_err_i  (rx_err_i),
        .hold_i    (outs.ser_rst || outs.proto_rst),
        .in_check_i(phase == PH_CHECK),
        .loss_done (loss_done),
        .lock_done (lock_done),
        .err_done  (err_done)
    );

    xrst_phase_fsm #(
        .SER_W  (SER_CNT_W),
        .PROTO_W(PROTO_CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .force_ser  (force_ser),
        .force_proto(force_proto),
        .loss_done  (loss_done),
        .lock_done  (lock_done),
        .err_done   (err_done),
        .phase      (phase)
    );

    assign ser_rst_o   = outs.ser_rst;
    assign proto_rst_o = outs.proto_rst;
    assign ready_o     = outs.ready;

    // R4: either serializer request gives serializer reset next cycle
    a_r4_ser_force: assert property (@(posedge clk) disable iff (rst)
        force_ser |=> (ser_rst_o && proto_rst_o && !ready_o));

    // R5: protocol request outside serializer phase gives protocol-only reset
    a_r5_proto_force: assert property (@(posedge clk) disable iff (rst)
        (force_proto && !force_ser && !loss_done && !ser_rst_o) |=> (proto_rst_o && !ser_rst_o));

    // R7: ready can only rise out of the stability check
    a_r7_ready_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(phase == PH_CHECK));

    // R2: at most one of the three outputs signals the ready phase
    a_r2_ready_excl: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !(ser_rst_o || proto_rst_o));

endmodule

// File: tb/sim_xcvr_path_rst_seq.sv
module sim_xcvr_path_rst_seq;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_sh = 1'b0, ser_pa = 1'b0, pr_sh = 1'b0, pr_pa = 1'b0;
    logic lol = 1'b0, rx_err = 1'b0;
    logic ser_rst, proto_rst, rdy;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    xcvr_path_rst_seq #(
        .SER_CNT_W(2), .PROTO_CNT_W(3), .LOCK_CNT_W(4), .ERR_CNT_W(3), .LOSS_CNT_W(4)
    ) u0 (
        .clk(clk), .rst(rst),
        .ser_rst_shared_i(ser_sh), .ser_rst_path_i(ser_pa),
        .proto_rst_shared_i(pr_sh), .proto_rst_path_i(pr_pa),
        .lol_i(lol), .rx_err_i(rx_err),
        .ser_rst_o(ser_rst), .proto_rst_o(proto_rst), .ready_o(rdy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic s, input logic p, input logic r);
        total++;
        if ({ser_rst, proto_rst, rdy} !== {s, p, r}) begin
            fails++;
            $display("FAIL %s: ser/proto/ready got %b%b%b expected %b%b%b",
                     req, ser_rst, proto_rst, rdy, s, p, r);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        {ser_sh, ser_pa, pr_sh, pr_pa, lol, rx_err} = '0;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    // R1 R2 R3: reset state and clean bring-up timing
    task automatic t_bringup();
        @(negedge clk); rst = 1'b1; tick(2);
        expect_out("R1", 1, 1, 0);
        rst = 1'b0;
        tick(3);  expect_out("R3", 1, 1, 0);
        tick(1);  expect_out("R3", 0, 1, 0);
        tick(7);  expect_out("R3", 0, 1, 0);
        tick(1);  expect_out("R2", 0, 0, 0);
        tick(15); expect_out("R7", 0, 0, 0);
        tick(1);  expect_out("R2", 0, 0, 1);
    endtask

    // R5: protocol requests ignored in serializer phase
    task automatic t_proto_in_ser();
        do_reset();
        pr_sh = 1'b1; pr_pa = 1'b1;
        tick(2);
        pr_sh = 1'b0; pr_pa = 1'b0;
        tick(1); expect_out("R5", 1, 1, 0);
        tick(1); expect_out("R5", 0, 1, 0);
    endtask

    // R8: non-consecutive errors send check back to protocol reset
    task automatic t_err_retry();
        do_reset();
        tick(12);
        rx_err = 1'b1; tick(3);
        rx_err = 1'b0; tick(2);
        rx_err = 1'b1; tick(4);
        rx_err = 1'b0;
        expect_out("R8", 0, 0, 0);
        tick(1);  expect_out("R8", 0, 1, 0);
        tick(23); expect_out("R8", 0, 0, 0);
        tick(1);  expect_out("R8", 0, 0, 1);
    endtask

    // R8: error completion wins over lock completion
    task automatic t_err_priority();
        do_reset();
        tick(20);
        rx_err = 1'b1; tick(7);
        rx_err = 1'b0;
        expect_out("R8", 0, 0, 0);
        tick(1); expect_out("R8", 0, 1, 0);
    endtask

    // R9: errors outside the check phase have no effect
    task automatic t_err_ignored();
        do_reset();
        rx_err = 1'b1; tick(12);
        rx_err = 1'b0;
        tick(16); expect_out("R9", 0, 0, 1);
        rx_err = 1'b1; tick(20);
        expect_out("R9", 0, 0, 1);
        rx_err = 1'b0;
    endtask

    // R7: one-cycle lock blip restarts the lock window
    task automatic t_lock_blip();
        do_reset();
        tick(16);
        lol = 1'b1; tick(1);
        lol = 1'b0;
        tick(15); expect_out("R7", 0, 0, 0);
        tick(1);  expect_out("R7", 0, 0, 1);
    endtask

    // R6: short loss run filtered, long run restarts sequence
    task automatic t_loss();
        do_reset(); tick(28);
        lol = 1'b1; tick(10);
        lol = 1'b0; tick(1);
        expect_out("R6", 0, 0, 1);
        lol = 1'b1; tick(15);
        expect_out("R6", 0, 0, 1);
        tick(1);  expect_out("R6", 1, 1, 0);
        tick(10); expect_out("R6", 1, 1, 0);
        lol = 1'b0;
        tick(28); expect_out("R6", 0, 0, 0);
        tick(1);  expect_out("R6", 0, 0, 1);
    endtask

    // R4: serializer requests restart the whole sequence
    task automatic t_ser_force();
        do_reset(); tick(28);
        ser_pa = 1'b1; tick(1);
        ser_pa = 1'b0;
        expect_out("R4", 1, 1, 0);
        tick(28); expect_out("R4", 0, 0, 1);
        ser_sh = 1'b1; tick(6);
        ser_sh = 1'b0;
        tick(3); expect_out("R4", 1, 1, 0);
        tick(1); expect_out("R4", 0, 1, 0);
    endtask

    // R5: protocol request from ready gives protocol-only reset
    task automatic t_proto_force();
        do_reset(); tick(28);
        pr_pa = 1'b1; tick(1);
        pr_pa = 1'b0;
        expect_out("R5", 0, 1, 0);
        tick(7);  expect_out("R5", 0, 1, 0);
        tick(1);  expect_out("R5", 0, 0, 0);
        tick(15); expect_out("R5", 0, 0, 0);
        tick(1);  expect_out("R5", 0, 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_bringup();
        t_proto_in_ser();
        t_err_retry();
        t_err_priority();
        t_err_ignored();
        t_lock_blip();
        t_loss();
        t_ser_force();
        t_proto_force();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule